// File: doc/BRIEF.md
# Layered Decode Sequencer with Syndrome Early Exit

This block sequences a row-serial (layered) LDPC decode. When a start pulse is accepted, it walks the seven base-matrix layers in order. Each layer takes three cycles: read, update and write. After the last layer it spends one evaluation cycle on the parity-check results of the current hard decisions. The datapath follows the layer index, the phase and the evaluation strobe. The message arithmetic and the memories are outside this block.

In the evaluation cycle the block counts the unsatisfied checks presented on its parity input. It records that count as the syndrome weight. It then either starts the next iteration or finishes. The decode finishes when the programmed iteration limit is reached. When early exit is enabled, it also finishes as soon as an evaluation finds a zero weight. When the decode finishes, the block reports how many iterations it ran, the last weight, and whether that weight was zero. These values are held until the next start.

Top module: `ldpc_layer_sequencer`

## Requirements
- R1: After reset, busy_o, eval_o, converged_o, iters_used_o, synd_wt_o, layer_o and phase_o are all zero.
- R2: A start_i pulse is accepted only while busy_o is low. busy_o is high from the first cycle after acceptance. A start_i pulse while busy_o is high has no effect on the running decode or its results.
- R3: Every iteration visits layers 0 to 6 in ascending order. Each layer spends three cycles, with phase_o taking the values 0 (read), 1 (update) and 2 (write). A single cycle with eval_o high follows. An iteration therefore occupies 22 cycles, and eval_o is high only in that last cycle.
- R4: The iteration limit is taken from iter_limit_i when start is accepted, and a value of 0 means one iteration. With early_exit_en_i low at acceptance, the decode runs exactly the limit, even if the weight reaches zero earlier. busy_o then stays high for 22 times the limit cycles.
- R5: With early_exit_en_i high at acceptance, the decode ends after the first iteration whose evaluation gives a zero weight, or at the limit if that comes first.
- R6: When the decode ends, converged_o is 1 if the weight of the last evaluation was exactly zero, and 0 otherwise.
- R7: synd_wt_o is the number of ones on parity_i in the evaluation cycle of the last iteration. Bit i set means check i is unsatisfied. The count saturates at 255.
- R8: When the decode ends, iters_used_o gives the number of iterations performed.
- R9: converged_o, iters_used_o and synd_wt_o are cleared when a start is accepted. While busy_o is low they stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a decode |
| early_exit_en_i | input | 1 | Allow stopping on a zero syndrome |
| iter_limit_i | input | 5 | Maximum iterations (0 is treated as 1) |
| parity_i | input | 224 | Per-check unsatisfied flags, sampled during eval_o |
| busy_o | output | 1 | Decode in progress |
| eval_o | output | 1 | Syndrome evaluation cycle |
| layer_o | output | 3 | Current layer index |
| phase_o | output | 2 | Phase in the layer: 0 read, 1 update, 2 write |
| converged_o | output | 1 | Last evaluated weight was zero |
| iters_used_o | output | 5 | Iterations performed |
| synd_wt_o | output | 8 | Last evaluated syndrome weight |

## Verification
Decodes are run under several conditions:
- A syndrome that never clears, at several limits including 0, 1, 3 and 31, separates limit handling from early exit.
- A syndrome that clears at a chosen iteration, with early exit on, shows the stop happens in the iteration the zero weight appears and not one later.
- The same clearing syndrome with early exit off shows the decode runs to the limit but still reports convergence.
- A syndrome that clears on exactly the last allowed iteration covers the case where both stop conditions meet.
- Syndrome weights of 1, 5, 9, 17 and all 224 checks confirm the count.
- A second start pulse in the middle of a decode must leave the cycle count and the results unchanged.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAYER = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seqc_rst_sync.sv
module seqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  // assert asynchronously, release after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seqc_layer_walk.sv
module seqc_layer_walk #(
  parameter  int NUM_LAYERS = 7,
  parameter  int STEPS      = 3,
  localparam int LW         = $clog2(NUM_LAYERS),
  localparam int PW         = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [LW-1:0] layer_o,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam logic [LW-1:0] LAST_LAYER = LW'(NUM_LAYERS - 1);
  localparam logic [PW-1:0] LAST_PHASE = PW'(STEPS - 1);

  logic [LW-1:0] layer_q, layer_d;
  logic [PW-1:0] phase_q, phase_d;
  logic          walk_en;

  assign walk_en = clr_i | adv_i;

  always_comb begin
    layer_d = layer_q;
    phase_d = phase_q;
    if (clr_i) begin
      layer_d = '0;
      phase_d = '0;
    end else if (adv_i) begin
      if (phase_q == LAST_PHASE) begin
        phase_d = '0;
        layer_d = (layer_q == LAST_LAYER) ? '0 : layer_q + 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      layer_q <= '0;
      phase_q <= '0;
    end else if (walk_en) begin
      layer_q <= layer_d;
      phase_q <= phase_d;
    end
  end

  assign layer_o = layer_q;
  assign phase_o = phase_q;
  assign last_o  = (layer_q == LAST_LAYER) && (phase_q == LAST_PHASE);
endmodule

// File: rtl/seqc_iter_track.sv
module seqc_iter_track #(
  parameter int ITER_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ITER_W-1:0] limit_i,
  input  logic              inc_i,
  output logic [ITER_W-1:0] done_cnt_o,
  output logic              final_o
);
  logic [ITER_W-1:0] lim_q, lim_d;
  logic [ITER_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic [ITER_W:0]   done_wide;

  // a zero limit still runs one iteration
  assign lim_d  = (limit_i == '0) ? ITER_W'(1) : limit_i;
  assign idx_en = load_i | inc_i;

  always_comb begin
    idx_d = idx_q;
    if (load_i)     idx_d = '0;
    else if (inc_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= ITER_W'(1);
    else if (load_i) lim_q <= lim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign done_wide  = {1'b0, idx_q} + (ITER_W + 1)'(1);
  assign done_cnt_o = done_wide[ITER_W-1:0];
  assign final_o    = done_wide >= {1'b0, lim_q};
endmodule

// File: rtl/seqc_synd_count.sv
module seqc_synd_count #(
  parameter  int NUM_CHECKS = 224,
  parameter  int WT_W       = 8,
  parameter  int GRP        = 16,
  localparam int NGRP       = (NUM_CHECKS + GRP - 1) / GRP,
  localparam int GW         = $clog2(GRP + 1),
  localparam int SW         = $clog2(NUM_CHECKS + 1),
  localparam int WMAX       = (1 << WT_W) - 1
) (
  input  logic [NUM_CHECKS-1:0] bits_i,
  output logic [WT_W-1:0]       wt_o,
  output logic                  zero_o
);
  logic [NGRP*GRP-1:0] padded;
  logic [NGRP*GW-1:0]  grp_flat;
  logic [SW-1:0]       total;

  always_comb begin
    padded                 = '0;
    padded[NUM_CHECKS-1:0] = bits_i;
  end

  // first stage: one small counter per group of checks
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int b = 0; b < GRP; b++) cnt = cnt + GW'(padded[g*GRP + b]);
    end
    assign grp_flat[g*GW +: GW] = cnt;
  end

  // second stage: sum of the group counts
  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = total + SW'(grp_flat[g*GW +: GW]);
  end

  assign wt_o   = (32'(total) > WMAX) ? '1 : WT_W'(total);
  assign zero_o = (total == '0);
endmodule

// File: rtl/ldpc_layer_sequencer.sv
module ldpc_layer_sequencer
  import seqc_pkg::*;
#(
  parameter  int NUM_LAYERS = 7,
  parameter  int STEPS      = 3,
  parameter  int ITER_W     = 5,
  parameter  int NUM_CHECKS = 224,
  parameter  int WT_W       = 8,
  localparam int LW         = $clog2(NUM_LAYERS),
  localparam int PW         = $clog2(STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  early_exit_en_i,
  input  logic [ITER_W-1:0]     iter_limit_i,
  input  logic [NUM_CHECKS-1:0] parity_i,
  output logic                  busy_o,
  output logic                  eval_o,
  output logic [LW-1:0]         layer_o,
  output logic [PW-1:0]         phase_o,
  output logic                  converged_o,
  output logic [ITER_W-1:0]     iters_used_o,
  output logic [WT_W-1:0]       synd_wt_o
);
  logic              rst_sync_n;
  seq_state_e        state_q, state_d;
  logic              start_ok, in_check, stop_now;
  logic              walk_last, iter_final;
  logic [ITER_W-1:0] done_cnt;
  logic [WT_W-1:0]   cur_wt;
  logic              cur_zero;
  logic              exit_en_q;
  logic              conv_q, conv_d;
  logic [ITER_W-1:0] used_q, used_d;
  logic [WT_W-1:0]   wt_q, wt_d;
  logic              stat_en;

  seqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign busy_o   = (state_q == ST_LAYER) || (state_q == ST_CHECK);
  assign in_check = (state_q == ST_CHECK);
  assign start_ok = start_i && !busy_o;

  seqc_layer_walk #(.NUM_LAYERS(NUM_LAYERS), .STEPS(STEPS)) u_walk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (start_ok | in_check),
    .adv_i   (state_q == ST_LAYER),
    .layer_o (layer_o),
    .phase_o (phase_o),
    .last_o  (walk_last)
  );

  seqc_synd_count #(.NUM_CHECKS(NUM_CHECKS), .WT_W(WT_W)) u_cnt (
    .bits_i (parity_i),
    .wt_o   (cur_wt),
    .zero_o (cur_zero)
  );

  assign stop_now = (exit_en_q && cur_zero) || iter_final;

  seqc_iter_track #(.ITER_W(ITER_W)) u_iter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (start_ok),
    .limit_i    (iter_limit_i),
    .inc_i      (in_check && !stop_now),
    .done_cnt_o (done_cnt),
    .final_o    (iter_final)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_LAYER;
      ST_LAYER: if (walk_last) state_d = ST_CHECK;
      ST_CHECK: state_d = stop_now ? ST_DONE : ST_LAYER;
      ST_DONE:  state_d = start_ok ? ST_LAYER : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   exit_en_q <= 1'b0;
    else if (start_ok) exit_en_q <= early_exit_en_i;
  end

  // status: cleared on accepted start, refreshed every evaluation
  assign stat_en = start_ok | in_check;

  always_comb begin
    conv_d = conv_q;
    used_d = used_q;
    wt_d   = wt_q;
    if (start_ok) begin
      conv_d = 1'b0;
      used_d = '0;
      wt_d   = '0;
    end else if (in_check) begin
      conv_d = cur_zero;
      used_d = done_cnt;
      wt_d   = cur_wt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      conv_q <= 1'b0;
      used_q <= '0;
      wt_q   <= '0;
    end else if (stat_en) begin
      conv_q <= conv_d;
      used_q <= used_d;
      wt_q   <= wt_d;
    end
  end

  assign eval_o       = in_check;
  assign converged_o  = conv_q;
  assign iters_used_o = used_q;
  assign synd_wt_o    = wt_q;
endmodule

// File: rtl/seqc_checker.sv
module seqc_checker #(
  parameter  int NUM_LAYERS = 7,
  parameter  int STEPS      = 3,
  parameter  int ITER_W     = 5,
  parameter  int WT_W       = 8,
  localparam int LW         = $clog2(NUM_LAYERS),
  localparam int PW         = $clog2(STEPS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              eval_o,
  input logic [LW-1:0]     layer_o,
  input logic [PW-1:0]     phase_o,
  input logic              converged_o,
  input logic [ITER_W-1:0] iters_used_o,
  input logic [WT_W-1:0]   synd_wt_o
);
  a_r2_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !eval_o && phase_o != PW'(STEPS - 1)) |=>
      (phase_o == PW'($past(phase_o) + 1'b1)) && $stable(layer_o));

  a_r3_eval_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !eval_o && layer_o == LW'(NUM_LAYERS - 1) && phase_o == PW'(STEPS - 1))
      |=> eval_o);

  a_r3_eval_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eval_o |-> busy_o);

  a_r6_conv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    converged_o |-> (synd_wt_o == '0));

  a_r8_used_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (iters_used_o != '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=>
      ($stable(iters_used_o) && $stable(converged_o) && $stable(synd_wt_o)));
endmodule

bind ldpc_layer_sequencer seqc_checker #(
  .NUM_LAYERS (NUM_LAYERS),
  .STEPS      (STEPS),
  .ITER_W     (ITER_W),
  .WT_W       (WT_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .eval_o       (eval_o),
  .layer_o      (layer_o),
  .phase_o      (phase_o),
  .converged_o  (converged_o),
  .iters_used_o (iters_used_o),
  .synd_wt_o    (synd_wt_o)
);

// File: tb/test_ldpc_layer_sequencer.sv
module test_ldpc_layer_sequencer;
  localparam int NC      = 224;
  localparam int LAYERS  = 7;
  localparam int STEPS   = 3;
  localparam int ITER_CY = LAYERS * STEPS + 1;

  typedef struct {
    int iters;
    bit conv;
    int wt;
    int cycles;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          exit_en;
  logic [4:0]    limit;
  logic [NC-1:0] parity;
  logic          busy, eval_s, conv;
  logic [2:0]    layer;
  logic [1:0]    phase;
  logic [4:0]    used;
  logic [7:0]    wt;

  int n_checks = 0;
  int n_errors = 0;
  exp_t exp_q[$];
  exp_t last_exp;

  logic [NC-1:0] noise;
  int conv_at    = 99;
  int evals_seen = 0;
  bit was_eval   = 0;
  int busy_cnt   = 0;
  bit busy_prev  = 0;
  bit seq_bad    = 0;
  int seq_first  = 0;
  bit finished   = 0;

  always #10ns clk = ~clk;

  assign parity = (evals_seen + 1 >= conv_at) ? '0 : noise;

  ldpc_layer_sequencer i_ldpc_layer_sequencer (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start),
    .early_exit_en_i (exit_en),
    .iter_limit_i    (limit),
    .parity_i        (parity),
    .busy_o          (busy),
    .eval_o          (eval_s),
    .layer_o         (layer),
    .phase_o         (phase),
    .converged_o     (conv),
    .iters_used_o    (used),
    .synd_wt_o       (wt)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // syndrome source: advances one iteration after each evaluation cycle
  always @(negedge clk) begin
    if (was_eval) evals_seen++;
    was_eval = eval_s;
  end

  // monitor: schedule order every busy cycle, results when busy falls
  always @(negedge clk) begin
    if (busy) begin
      int pos;
      pos = busy_cnt % ITER_CY;
      if (pos < LAYERS * STEPS) begin
        if (eval_s || layer != 3'(pos / STEPS) || phase != 2'(pos % STEPS)) begin
          if (!seq_bad) seq_first = pos;
          seq_bad = 1;
        end
      end else if (!eval_s) begin
        if (!seq_bad) seq_first = pos;
        seq_bad = 1;
      end
      busy_cnt++;
    end
    if (busy_prev && !busy) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected completion", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        last_exp = e;
        check(!seq_bad, "R3 layer/phase/eval order, first bad slot", seq_first, -1);
        check(busy_cnt == e.cycles, "R4 busy cycles", busy_cnt, e.cycles);
        check(int'(used) == e.iters, "R8 iterations used", used, e.iters);
        check(conv == e.conv, "R6 converged flag", conv, e.conv);
        check(int'(wt) == e.wt, "R7 syndrome weight", wt, e.wt);
      end
      busy_cnt = 0;
      seq_bad  = 0;
    end
    busy_prev = busy;
  end

  // driver: computes the expected result, queues it, runs the decode
  task automatic run_decode(input int lim, input bit en, input int cat,
                            input int nz, input bit poke);
    exp_t e;
    int   l;
    l = (lim == 0) ? 1 : lim;
    if (en && cat <= l) e.iters = (cat < 1) ? 1 : cat;
    else                e.iters = l;
    e.conv   = (e.iters >= cat);
    e.wt     = e.conv ? 0 : nz;
    e.cycles = ITER_CY * e.iters;
    for (int i = 0; i < NC; i++) noise[i] = (((i * 5) % NC) < nz);
    conv_at    = cat;
    evals_seen = 0;
    was_eval   = 0;
    exp_q.push_back(e);
    @(negedge clk);
    limit   = 5'(lim);
    exit_en = en;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(used == '0 && wt == '0 && !conv, "R9 status cleared on start", used, 0);
    if (poke) begin
      repeat (30) @(negedge clk);
      limit   = 5'd1;
      exit_en = 1'b1;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    exit_en = 1'b0;
    limit   = '0;
    noise   = '0;
    repeat (5) @(negedge clk);
    // R1: reset values
    check(!busy && !eval_s && !conv && used == '0 && wt == '0 && layer == '0 && phase == '0,
          "R1 reset state", {busy, eval_s, conv}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && used == '0 && wt == '0, "R1 idle after release", busy, 0);

    run_decode(3, 0, 99, 17, 0);   // R4, R7: limit runs out
    repeat (8) @(negedge clk);     // R9: hold while idle
    check(int'(used) == last_exp.iters && int'(wt) == last_exp.wt && conv == last_exp.conv,
          "R9 status held while idle", used, last_exp.iters);
    run_decode(0, 0, 99, 5, 0);    // R4: zero limit means one
    run_decode(30, 1, 4, 12, 0);   // R5: early exit at 4
    run_decode(6, 0, 2, 9, 0);     // R4: zero weight ignored when exit off
    run_decode(5, 1, 1, 3, 0);     // R5: converged in first iteration
    run_decode(4, 1, 99, 224, 0);  // R7: every check failing
    run_decode(31, 1, 40, 1, 0);   // R4: full 5-bit limit
    run_decode(5, 0, 99, 9, 1);    // R2: start while busy ignored
    run_decode(2, 1, 2, 7, 0);     // R5, R6: clears on last iteration
    run_decode(1, 0, 99, 200, 0);  // R8: single iteration by limit

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all decodes completed", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule